// File: doc/BRIEF.md
# Unaligned Word-Read Byte Realigner

This block fetches a payload that may begin at any byte address through a bus that only moves whole 32-bit words. It is given a byte start address and a payload size counted in 32-bit words. From these it works out how many bus words must be read, and it issues word-aligned burst requests. It then takes the returned words and shifts them so that the payload comes out as packed 32-bit words, with the first payload byte in lane 0.

When the start address has a nonzero byte offset, the payload spans one more bus word than its nominal size. The read is lengthened by that single word. The bytes in front of the payload in the first word are discarded inside the block, and so are the bytes after it in the last word. Only payload bytes reach the output.

An optional line-split mode breaks the read into several requests so that none of them crosses a `CACHE_WORDS`-word line. The word count for the whole transfer is still the spanned total. The split does not add an extra word to each piece.

Top module: `dma_rd_realign`

## Requirements
- R1: `cmd_ready` is high only while no transfer is in progress. It drops after a command is accepted and rises again once the output word flagged last has been taken. While it is low, `cmd_valid` is ignored.
- R2: Without line-split mode, one request is issued per transfer. Its `req_len` is the nominal word count N when `cmd_addr[1:0]==0`, and N+1 otherwise.
- R3: Every `req_addr` has bits [1:0] at zero. The first request starts at `cmd_addr` with bits [1:0] cleared, and each later request starts at the previous `req_addr` plus 4×`req_len`.
- R4: In line-split mode (`cmd_split`=1), no request crosses a `CACHE_WORDS`-word aligned line. The lengths of all requests in the transfer add up to N, or to N+1 when unaligned, with no extra word per piece.
- R5: Output word k carries, in lane j (bits 8j+7:8j, little-endian lanes), the byte at address `cmd_addr`+4k+j.
- R6: Exactly N words are emitted per transfer. Bytes before `cmd_addr` and bytes after the payload end never appear on the output.
- R7: With a word-aligned start, the returned words pass to the output unchanged and in order, with no extra bus word read.
- R8: `out_last` is high on the Nth output word and low on all others.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values and `rsp_ready` is low.
- R10: During and right after reset, `cmd_ready`=1, `req_valid`=0, `rsp_ready`=0 and `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Transfer command present |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_addr | input | ADDR_W | Byte start address of payload |
| cmd_words | input | LEN_W | Payload size N in words (N ≥ 1) |
| cmd_split | input | 1 | Split the read at line boundaries |
| req_valid | output | 1 | Burst request present |
| req_ready | input | 1 | Bus took the request |
| req_addr | output | ADDR_W | Word-aligned byte address of burst |
| req_len | output | LEN_W+1 | Burst length in words |
| rsp_valid | input | 1 | Read word returned |
| rsp_ready | output | 1 | Block takes the returned word |
| rsp_data | input | 32 | Returned word, lane n = address offset n |
| out_valid | output | 1 | Packed payload word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Packed payload word |
| out_last | output | 1 | Final payload word of the transfer |

## Verification
The hardest case to reach from the ports is an unaligned transfer in line-split mode where a request boundary, a stalled output and the swallowed first beat all happen close together. In that case the holding bytes must survive both a pause in the bus and a pause at the consumer. To get there, the bench runs every byte offset with payloads of 1, 2, 12 and 60 words, in both modes. It applies independent random stalls to request acceptance, word return and output acceptance. A behavioural model checks every request address and length and every output word on each clock.

// File: rtl/dma_rd_realign_pkg.sv
package dma_rd_realign_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;

  // Join the upper three bytes of the previous bus word with the head of the
  // current one, starting at byte offset off (lane n = address offset n).
  function automatic logic [WORD_W-1:0] realign(
      input logic [WORD_W-BYTE_W-1:0] hold,
      input logic [WORD_W-1:0]        cur,
      input logic [1:0]               off);
    logic [WORD_W-1:0] r;
    case (off)
      2'd1:    r = {cur[7:0],  hold[23:0]};
      2'd2:    r = {cur[15:0], hold[23:8]};
      2'd3:    r = {cur[23:0], hold[23:16]};
      default: r = cur;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rlgn_burst_gen.sv
module rlgn_burst_gen #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 8,
  parameter int CACHE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-3:0] start_widx,
  input  logic [LEN_W:0]    total_beats,
  input  logic              split,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W:0]    req_len
);
  localparam int BEAT_W = LEN_W + 1;
  localparam int CW_LOG = (CACHE_WORDS > 1) ? $clog2(CACHE_WORDS) : 1;

  logic              active_q;
  logic              split_q;
  logic [ADDR_W-3:0] widx_q;
  logic [BEAT_W-1:0] left_q;
  logic [BEAT_W-1:0] room;
  logic [BEAT_W-1:0] chunk;

  always_comb begin
    room  = BEAT_W'(CACHE_WORDS) - BEAT_W'(widx_q[CW_LOG-1:0]);
    chunk = (split_q && (room < left_q)) ? room : left_q;
  end

  assign req_valid = active_q;
  assign req_addr  = {widx_q, 2'b00};
  assign req_len   = chunk;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      split_q  <= 1'b0;
      widx_q   <= '0;
      left_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      split_q  <= split;
      widx_q   <= start_widx;
      left_q   <= total_beats;
    end else if (active_q && req_ready) begin
      widx_q   <= widx_q + (ADDR_W-2)'(chunk);
      left_q   <= left_q - chunk;
      if (left_q == chunk) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rlgn_shifter.sv
module rlgn_shifter #(
  parameter int LEN_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [1:0]  offset,
  input  logic [LEN_W:0] total_beats,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [31:0] rsp_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_last
);
  import dma_rd_realign_pkg::*;

  logic [1:0]     off_q;
  logic           first_q;
  logic [LEN_W:0] beats_q;
  logic [23:0]    hold_q;
  logic           take;

  assign rsp_ready = (beats_q != '0) && (!out_valid || out_ready);
  assign take      = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q     <= 2'd0;
      first_q   <= 1'b0;
      beats_q   <= '0;
      hold_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (start) begin
        off_q   <= offset;
        first_q <= (offset != 2'd0);
        beats_q <= total_beats;
      end else if (take) begin
        beats_q <= beats_q - 1'b1;
        hold_q  <= rsp_data[31:8];
        if (first_q) begin
          first_q <= 1'b0;
        end else begin
          out_valid <= 1'b1;
          out_data  <= realign(hold_q, rsp_data, off_q);
          out_last  <= (beats_q == (LEN_W+1)'(1));
        end
      end
    end
  end
endmodule

// File: rtl/dma_rd_realign.sv
module dma_rd_realign #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 8,
  parameter int CACHE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_words,
  input  logic              cmd_split,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W:0]    req_len,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic              out_last
);
  logic           busy_q;
  logic           cmd_fire;
  logic [LEN_W:0] total_beats;

  assign cmd_ready   = !busy_q;
  assign cmd_fire    = cmd_valid && !busy_q;
  assign total_beats = {1'b0, cmd_words} + (LEN_W+1)'(cmd_addr[1:0] != 2'd0);

  always_ff @(posedge clk) begin
    if (rst)                                  busy_q <= 1'b0;
    else if (cmd_fire)                        busy_q <= 1'b1;
    else if (out_valid && out_ready && out_last) busy_q <= 1'b0;
  end

  rlgn_burst_gen #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CACHE_WORDS(CACHE_WORDS)
  ) u_gen (
    .clk(clk), .rst(rst), .start(cmd_fire),
    .start_widx(cmd_addr[ADDR_W-1:2]), .total_beats(total_beats),
    .split(cmd_split), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len)
  );

  rlgn_shifter #(.LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .start(cmd_fire), .offset(cmd_addr[1:0]),
    .total_beats(total_beats), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );
endmodule

// File: rtl/dma_rd_realign_chk.sv
module dma_rd_realign_chk #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 8,
  parameter int CACHE_WORDS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [LEN_W-1:0]  cmd_words,
  input logic              cmd_split,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W:0]    req_len,
  input logic              rsp_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [31:0]       out_data,
  input logic              out_last
);
  localparam int CW_LOG = (CACHE_WORDS > 1) ? $clog2(CACHE_WORDS) : 1;

  logic             split_q;
  logic [LEN_W-1:0] words_q;
  logic [LEN_W:0]   ocnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      split_q <= 1'b0;
      words_q <= '0;
      ocnt_q  <= '0;
    end else if (cmd_valid && cmd_ready) begin
      split_q <= cmd_split;
      words_q <= cmd_words;
      ocnt_q  <= '0;
    end else if (out_valid && out_ready) begin
      ocnt_q  <= ocnt_q + 1'b1;
    end
  end

  assert_req_word_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_addr[1:0] == 2'b00 && req_len != '0));

  assert_seg_in_line_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && split_q) |->
      (int'(req_addr[CW_LOG+1:2]) + int'(req_len) <= CACHE_WORDS));

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_no_take_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !rsp_ready);

  assert_busy_blocks_cmd_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !cmd_ready);

  assert_last_count_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> (int'(ocnt_q) == int'(words_q) - 1));
endmodule

bind dma_rd_realign dma_rd_realign_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CACHE_WORDS(CACHE_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_words(cmd_words), .cmd_split(cmd_split), .req_valid(req_valid),
  .req_addr(req_addr), .req_len(req_len), .rsp_ready(rsp_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last)
);

// File: tb/dma_rd_realign_tb.sv
`timescale 1ns/1ps
module dma_rd_realign_tb;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;
  localparam int CW     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 0, cmd_ready, cmd_split = 0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [LEN_W-1:0]  cmd_words = '0;
  logic req_valid, req_ready = 0;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W:0]    req_len;
  logic rsp_valid = 0, rsp_ready;
  logic [31:0] rsp_data = '0;
  logic out_valid, out_ready = 0, out_last;
  logic [31:0] out_data;

  always #10 clk = ~clk;

  dma_rd_realign #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CACHE_WORDS(CW)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_words(cmd_words), .cmd_split(cmd_split),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last));

  int errs = 0, checks = 0;
  bit run = 0;
  int stall = 0;
  logic [31:0] rsp_q[$];
  logic [31:0] exp_q[$];
  int exp_widx, beats_left, req_total, outs_seen, cur_n;
  bit cur_split;
  bit prev_stall = 0;
  logic [31:0] prev_data;
  logic prev_last;

  function automatic logic [7:0] mem_byte(int a);
    return 8'(a * 37 + (a >> 5) * 11 + 5);
  endfunction

  function automatic logic [31:0] mem_word_at(int a);
    return {mem_byte(a + 3), mem_byte(a + 2), mem_byte(a + 1), mem_byte(a)};
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bus model and reference comparison, evaluated once per clock
  always @(negedge clk) if (run) begin
    req_ready = ($urandom % 100) >= stall;
    out_ready = ($urandom % 100) >= stall;
    rsp_valid = (rsp_q.size() > 0) && (($urandom % 100) >= stall);
    rsp_data  = (rsp_q.size() > 0) ? rsp_q[0] : 32'h0;
    #1;
    if (prev_stall)
      chk(out_valid && out_data == prev_data && out_last == prev_last,
          "R9 stalled output held", out_data, prev_data);
    if (out_valid && !out_ready)
      chk(!rsp_ready, "R9 rsp_ready low while stalled", rsp_ready, 0);
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    prev_last  = out_last;
    if (req_valid && req_ready) begin
      chk(req_addr == ADDR_W'(exp_widx * 4), "R3 request address", req_addr, exp_widx * 4);
      chk(req_len > 0 && int'(req_len) <= beats_left, "R2 request length range",
          req_len, beats_left);
      if (cur_split)
        chk((exp_widx % CW) + int'(req_len) <= CW, "R4 line crossing",
            (exp_widx % CW) + req_len, CW);
      else
        chk(int'(req_len) == beats_left, "R2 single request length", req_len, beats_left);
      for (int i = 0; i < int'(req_len); i++) rsp_q.push_back(mem_word_at((exp_widx + i) * 4));
      exp_widx   += int'(req_len);
      beats_left -= int'(req_len);
      req_total  += int'(req_len);
    end
    if (rsp_valid && rsp_ready) void'(rsp_q.pop_front());
    if (out_valid && out_ready) begin
      logic [31:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hdeadbeef;
      chk(out_data == e, "R5 packed output word", out_data, e);
      chk(out_last == (outs_seen == cur_n - 1), "R8 last flag", out_last,
          outs_seen == cur_n - 1);
      outs_seen++;
    end
  end

  task automatic xfer(int addr, int n, bit split, int st);
    int extra;
    int cyc;
    extra = (addr % 4 != 0) ? 1 : 0;
    @(negedge clk);
    stall      = st;
    cur_n      = n;
    cur_split  = split;
    outs_seen  = 0;
    req_total  = 0;
    exp_widx   = addr / 4;
    beats_left = n + extra;
    for (int k = 0; k < n; k++) exp_q.push_back(mem_word_at(addr + 4 * k));
    cmd_valid = 1; cmd_addr = ADDR_W'(addr); cmd_words = LEN_W'(n); cmd_split = split;
    #2;
    chk(cmd_ready == 1'b1, "R1 idle accepts command", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 0;
    cyc = 0;
    while (outs_seen < n && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 3 && outs_seen < n) begin
        cmd_valid = 1; cmd_addr = 32'h1233; cmd_words = 8'd5; cmd_split = 0;
        #2;
        chk(cmd_ready == 1'b0, "R1 busy refuses command", cmd_ready, 0);
        @(negedge clk);
        cmd_valid = 0;
        cyc++;
      end
    end
    chk(cyc < 5000, "R6 transfer completes", cyc, 5000);
    repeat (4) @(negedge clk);
    #2;
    chk(outs_seen == n, "R6 output word count", outs_seen, n);
    chk(req_total == n + extra, extra ? "R2 total words unaligned" : "R7 aligned total words",
        req_total, n + extra);
    chk(rsp_q.size() == 0 && exp_q.size() == 0, "R6 nothing left over",
        rsp_q.size() + exp_q.size(), 0);
    chk(cmd_ready == 1'b1 && !out_valid, "R1 idle after last word", cmd_ready, 1);
    exp_q.delete();
    rsp_q.delete();
  endtask

  initial begin
    int sizes[4] = '{1, 2, 12, 60};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready == 1 && !req_valid && !rsp_ready && !out_valid, "R10 reset state",
        {cmd_ready, req_valid, rsp_ready, out_valid}, 4'b1000);
    rst = 0;
    @(negedge clk);
    #2;
    chk(cmd_ready == 1 && !req_valid && !rsp_ready && !out_valid, "R10 after reset",
        {cmd_ready, req_valid, rsp_ready, out_valid}, 4'b1000);
    run = 1;
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 4; o++)
        for (int z = 0; z < 4; z++)
          xfer(16'h0100 + 4 * (z * 3 + o) + o, sizes[z], bit'(s), (o + z) % 3 * 25);
    // 12-word cell at byte offset 2, fetched as 13 words, no stalls (R2, R5)
    xfer(32'h0000_2002, 12, 1'b0, 0);
    // 60 words at offset 3 across many lines in split mode under heavy stalls (R4)
    xfer(32'h0000_301F, 60, 1'b1, 60);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule